// File: doc/BRIEF.md
# Multiplexed LCD Waveform Sequencer

This block generates the drive waveform for a passive multiplexed LCD panel. It does not produce logic levels. For every panel pin it outputs a 3-bit index, and the analog bias ladder uses that index to pick one of six voltages: ground, or one of up to five drive levels. At runtime the block can be set to static drive or to 1/2, 1/3, 1/4 or 1/5 bias. It can drive from one to sixteen active commons. The polarity can reverse in the middle of every row (line inversion) or once per frame (frame inversion). A negative-image control complements every segment bit.

A configuration bit marks each pin as a common or a segment. A common pin `p` belongs to common row `p mod NUM_COM`. A segment pin `p` takes bit `p` of the row data. A programmable divider sets the length of each half row. At each row boundary the block copies a shadow register into the active row register and raises a request. An external transfer engine answers the request by writing the following row into the shadow through a one-cycle load strobe. A frame flag marks the boundary where the row counter wraps back to zero.

Top module: `lcd_wave_seq`

## Requirements
- R1: While `rst_ni` is low, `req_o` and `frame_o` are 0, row 0 is in its first (positive) half, and the active and shadow row data are all zero.
- R2: The block counts clock cycles. The first half-row tick comes at the first clock edge after reset. After that, one tick comes every `div_i`+1 cycles. A row lasts two ticks.
- R3: Rows advance from 0 to the last active common. The row after the last one is 0. `frame_o` is high in the same cycle as the `req_o` of the last row.
- R4: With bias level count N, a common pin in positive polarity drives N when its row is selected. When it is not selected it drives 1, or 0 under static drive. A common pin whose index is at or above the active count drives 0 in both polarities.
- R5: In positive polarity, a segment pin drives 0 when its effective bit is 1. When the bit is 0 it drives 2, or 1 under 1/2 bias and static drive.
- R6: In negative polarity, every active pin drives N minus its positive-polarity index.
- R7: With `wave_b_i`=0, polarity is positive in the first half of each row and negative in the second half. With `wave_b_i`=1, polarity stays the same for a whole frame, flips at each frame wrap, and starts positive after reset.
- R8: `invert_i`=1 complements the segment data before the level is chosen. Common pins are not affected.
- R9: `load_i` writes `load_data_i` into the shadow. The active row takes the shadow only at a row boundary, which is the edge that ends a cycle with `req_o`=1. A load in that same cycle stays in the shadow until the next boundary.
- R10: Under static drive (`bias_i`=0), exactly one common is active and `num_com_i` is ignored.
- R11: `bias_i` encodes 0=static (N=1), 1=1/2, 2=1/3, 3=1/4, 4=1/5 (N=`bias_i`+1). Codes 5 to 7 behave as 1/5. No pin ever drives an index above N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W | Half-row length minus one, in clock cycles |
| bias_i | input | 3 | Bias select (R11 encoding) |
| num_com_i | input | $clog2(NUM_COM) | Active commons minus one |
| wave_b_i | input | 1 | 0: line inversion, 1: frame inversion |
| invert_i | input | 1 | Negative image |
| pin_com_i | input | NUM_PINS | Per pin: 1 = common, 0 = segment |
| load_i | input | 1 | Shadow load strobe |
| load_data_i | input | NUM_PINS | Next row segment bits |
| req_o | output | 1 | Row boundary / next-row request |
| frame_o | output | 1 | Frame wrap |
| pin_lvl_o | output | 3*NUM_PINS | Bias level index per pin, pin p at bits 3p+2:3p |

## Verification
The bench loads the shadow on every cycle, including the boundary cycle. A design that copied the new data straight through would show the next row early, and the check would find a row that differs from the one the reference model expects. The bench checks both polarity styles under several bias ratios. An error in the 1/2-bias off level, or a line-style flip used in frame mode, shows up as a level error in one half of a row. It also runs static drive with a nonzero common count, and it sets commons above the active count. A design that obeyed `num_com_i` under static drive, or that drove those inactive commons, would produce extra select levels. It also runs a divider of zero and a bias code above 4. A miscounted divider shifts `req_o`, and an unclamped code drives indices above five.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  // highest level index for a bias code; out-of-range codes clamp to 1/5
  function automatic lvl_t bias_top(input logic [2:0] code);
    if (code >= 3'd4) return lvl_t'(5);
    return lvl_t'(code) + lvl_t'(1);
  endfunction
endpackage

// File: rtl/lcd_seq_timing.sv
module lcd_seq_timing #(
  parameter int DIV_W = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [ROW_W-1:0] last_row_i,
  input  logic             wave_b_i,
  output logic [ROW_W-1:0] row_o,
  output logic             neg_o,
  output logic             bound_o,
  output logic             frame_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [ROW_W-1:0] row_q;
  logic             half_q, fpar_q;
  logic             tick, wrap;

  assign tick    = (cnt_q == '0);
  assign bound_o = tick & half_q;
  assign wrap    = bound_o & (row_q >= last_row_i);
  assign frame_o = wrap;
  assign row_o   = row_q;
  assign neg_o   = wave_b_i ? fpar_q : half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= 1'b0;
      row_q  <= '0;
      fpar_q <= 1'b0;
    end else begin
      cnt_q <= tick ? div_i : cnt_q - 1'b1;
      if (tick) half_q <= ~half_q;
      if (bound_o) row_q <= wrap ? '0 : row_q + 1'b1;
      if (wrap) fpar_q <= ~fpar_q;
    end
  end

  // a row spans two ticks, so boundaries never touch
  a_r2_no_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bound_o |=> !bound_o);

  a_r7_frame_pol_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wave_b_i && !frame_o) |=> (!wave_b_i || $stable(neg_o)));
endmodule

// File: rtl/lcd_row_buf.sv
module lcd_row_buf #(
  parameter int NUM_PINS = 62
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [NUM_PINS-1:0] load_data_i,
  input  logic                xfer_i,
  output logic [NUM_PINS-1:0] active_o
);
  logic [NUM_PINS-1:0] shadow_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load_i) shadow_q <= load_data_i;
      if (xfer_i) active_q <= shadow_q;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/lcd_level_gen.sv
module lcd_level_gen
  import lcd_seq_pkg::*;
#(
  parameter int NUM_PINS = 62,
  parameter int NUM_COM  = 16,
  parameter int ROW_W    = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_com_i,
  input  logic [NUM_PINS-1:0]       active_i,
  input  logic [ROW_W-1:0]          row_i,
  input  logic [ROW_W-1:0]          last_row_i,
  input  logic                      neg_i,
  input  logic                      invert_i,
  input  lvl_t                      n_lvl_i,
  output logic [NUM_PINS*LVL_W-1:0] pin_lvl_o
);
  lvl_t unsel_lvl, off_lvl;
  assign unsel_lvl = (n_lvl_i == lvl_t'(1)) ? lvl_t'(0) : lvl_t'(1);
  assign off_lvl   = (n_lvl_i <= lvl_t'(2)) ? lvl_t'(1) : lvl_t'(2);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam logic [ROW_W-1:0] CI = ROW_W'(p % NUM_COM);
    lvl_t pos, lvl;
    logic live;

    always_comb begin
      live = 1'b1;
      if (pin_com_i[p]) begin
        live = (CI <= last_row_i);
        pos  = (CI == row_i) ? n_lvl_i : unsel_lvl;
      end else begin
        pos  = (active_i[p] ^ invert_i) ? lvl_t'(0) : off_lvl;
      end
      if (!live)      lvl = '0;
      else if (neg_i) lvl = n_lvl_i - pos;
      else            lvl = pos;
    end

    assign pin_lvl_o[p*LVL_W +: LVL_W] = lvl;

    a_r11_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pin_lvl_o[p*LVL_W +: LVL_W] <= n_lvl_i);
  end
endmodule

// File: rtl/lcd_wave_seq.sv
module lcd_wave_seq
  import lcd_seq_pkg::*;
#(
  parameter int NUM_PINS = 62,
  parameter int NUM_COM  = 16,
  parameter int DIV_W    = 16,
  localparam int ROW_W   = $clog2(NUM_COM)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DIV_W-1:0]          div_i,
  input  logic [2:0]                bias_i,
  input  logic [ROW_W-1:0]          num_com_i,
  input  logic                      wave_b_i,
  input  logic                      invert_i,
  input  logic [NUM_PINS-1:0]       pin_com_i,
  input  logic                      load_i,
  input  logic [NUM_PINS-1:0]       load_data_i,
  output logic                      req_o,
  output logic                      frame_o,
  output logic [NUM_PINS*LVL_W-1:0] pin_lvl_o
);
  localparam logic [ROW_W-1:0] MAX_ROW = ROW_W'(NUM_COM - 1);

  lvl_t                n_lvl;
  logic [ROW_W-1:0]    last_row, row;
  logic [NUM_PINS-1:0] active;
  logic                neg, bound;

  assign n_lvl    = bias_top(bias_i);
  assign last_row = (bias_i == 3'd0)     ? '0 :
                    (num_com_i > MAX_ROW) ? MAX_ROW : num_com_i;

  lcd_seq_timing #(.DIV_W(DIV_W), .ROW_W(ROW_W)) u_timing (
    .clk_i, .rst_ni, .div_i,
    .last_row_i (last_row),
    .wave_b_i,
    .row_o      (row),
    .neg_o      (neg),
    .bound_o    (bound),
    .frame_o
  );

  lcd_row_buf #(.NUM_PINS(NUM_PINS)) u_buf (
    .clk_i, .rst_ni, .load_i, .load_data_i,
    .xfer_i   (bound),
    .active_o (active)
  );

  lcd_level_gen #(.NUM_PINS(NUM_PINS), .NUM_COM(NUM_COM), .ROW_W(ROW_W)) u_lvl (
    .clk_i, .rst_ni, .pin_com_i,
    .active_i   (active),
    .row_i      (row),
    .last_row_i (last_row),
    .neg_i      (neg),
    .invert_i,
    .n_lvl_i    (n_lvl),
    .pin_lvl_o
  );

  assign req_o = bound;

  // displayed row data only moves on a requested boundary
  a_r9_active_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |=> $stable(active));
endmodule

// File: tb/sim_lcd_wave_seq.sv
module sim_lcd_wave_seq;
  localparam int NP = 62;
  localparam int NC = 16;

  logic          clk = 0, rst_n = 0;
  logic [15:0]   div = 0;
  logic [2:0]    bias = 0;
  logic [3:0]    ncom = 0;
  logic          wb = 0, inv = 0, load = 0;
  logic [NP-1:0] pins = 0, ldata = 0;
  logic          req, frame;
  logic [3*NP-1:0] lvls;

  int errors = 0, checks = 0;
  string tag = "R1";
  bit checking = 0;

  int m_cnt, m_half, m_row, m_fp;
  logic [NP-1:0] m_sh, m_act;
  logic [63:0] lf = 64'h1234_5678_9abc_def1;

  always #5 clk = ~clk;

  lcd_wave_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div), .bias_i(bias), .num_com_i(ncom),
    .wave_b_i(wb), .invert_i(inv), .pin_com_i(pins), .load_i(load),
    .load_data_i(ldata), .req_o(req), .frame_o(frame), .pin_lvl_o(lvls)
  );

  function automatic int ncom_eff();
    return (bias == 0) ? 1 : int'(ncom) + 1;
  endfunction

  function automatic logic [3*NP-1:0] expect_lvls();
    logic [3*NP-1:0] r;
    int n = (bias >= 4) ? 5 : int'(bias) + 1;
    int nc = ncom_eff();
    int neg = wb ? m_fp : m_half;
    for (int p = 0; p < NP; p++) begin
      int v, pos;
      if (pins[p]) begin
        int ci = p % NC;
        if (ci >= nc) v = 0;
        else begin
          pos = (ci == m_row) ? n : ((n == 1) ? 0 : 1);
          v = neg ? n - pos : pos;
        end
      end else begin
        pos = (m_act[p] ^ inv) ? 0 : ((n <= 2) ? 1 : 2);
        v = neg ? n - pos : pos;
      end
      r[3*p +: 3] = 3'(v);
    end
    return r;
  endfunction

  // reference model: follows the requirement text with integers
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_half = 0; m_row = 0; m_fp = 0; m_sh = '0; m_act = '0;
    end else begin
      logic [NP-1:0] nsh;
      nsh = load ? ldata : m_sh;
      if (m_cnt == 0) begin
        m_cnt = int'(div);
        if (m_half == 0) m_half = 1;
        else begin
          m_half = 0;
          m_act = m_sh;
          if (m_row >= ncom_eff() - 1) begin m_row = 0; m_fp ^= 1; end
          else m_row++;
        end
      end else m_cnt--;
      m_sh = nsh;
    end
  end

  task automatic cmp(input string t);
    logic e_req, e_frame;
    logic [3*NP-1:0] e_l;
    e_req = (m_cnt == 0) && (m_half == 1);
    e_frame = e_req && (m_row >= ncom_eff() - 1);
    e_l = expect_lvls();
    checks++;
    if (req !== e_req || frame !== e_frame || lvls !== e_l) begin
      errors++;
      $display("FAIL %s t=%0t req=%b/%b frame=%b/%b lvls act=%h exp=%h",
               t, $time, req, e_req, frame, e_frame, lvls, e_l);
    end
  endtask

  always @(negedge clk) if (rst_n && checking) cmp(tag);

  task automatic scen(input string t, input int d, input int b, input int nc,
                      input bit w, input bit iv, input logic [NP-1:0] pc,
                      input int cyc, input int every);
    checking = 0;
    @(posedge clk); #1;
    rst_n = 0; load = 0;
    div = 16'(d); bias = 3'(b); ncom = 4'(nc); wb = w; inv = iv; pins = pc;
    @(negedge clk);
    cmp("R1");  // reset state
    @(posedge clk); #1;
    rst_n = 1; tag = t; checking = 1;
    for (int k = 0; k < cyc; k++) begin
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      load = (k % every) == 0;
      ldata = lf[NP-1:0];
      @(posedge clk); #1;
    end
    load = 0;
  endtask

  localparam logic [NP-1:0] PC = 62'h0000_0002_0010_FFFF;

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    scen("R4", 2, 2, 3, 0, 0, PC, 300, 3);        // 1/3, 4 commons, line inversion
    scen("R6", 3, 3, 7, 0, 0, PC, 400, 5);        // 1/4 mirror
    scen("R7", 1, 3, 7, 1, 0, PC, 400, 2);        // frame inversion
    scen("R5", 2, 1, 5, 0, 0, PC, 300, 4);        // 1/2 off level
    scen("R8", 2, 2, 3, 1, 1, PC, 300, 3);        // negative image
    scen("R10", 1, 0, 9, 0, 0, PC, 200, 2);       // static ignores count
    scen("R10", 2, 0, 3, 1, 1, PC, 200, 3);
    scen("R11", 1, 6, 15, 0, 0, PC, 500, 3);      // clamped code, 16 commons
    scen("R9", 0, 4, 2, 0, 0, 62'h0, 300, 1);     // load every cycle
    scen("R2", 0, 2, 1, 1, 0, PC, 200, 2);        // divider 0
    scen("R3", 4, 4, 15, 0, 0, PC, 800, 7);       // full frame wraps
    checking = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule